// File: doc/BRIEF.md
# Zoned External Bus Access Sequencer

This block drives the strobes of an external parallel bus for single read and write accesses. The bus is split into a number of address zones. Each zone carries its own timing word, which holds a lead, active and trail count for writes and a second set for reads. The word also holds a doubling flag and a ready-enable flag. An access always runs lead, then active, then trail. Chip select is held for the whole access. The read or write strobe is raised only while the active phase lasts.

All phase counting advances on a clock-enable tick that stands for the slower bus timing clock. The doubling flag stretches the programmed lead, active and trail counts by two. The one mandatory active cycle and any wait cycles that the ready input adds are never doubled. The block takes any programmed counts as they are, including zero, and does not police them. A requester offers an access with a valid pulse. The offer is taken only when the sequencer is idle, and a one-cycle done pulse ends every access.

Top module: `ext_bus_seq`

## Requirements
- R1: Chip select (`bus_cs_o`) is high from the cycle after a request is taken until the final tick of the access. The phases follow in the fixed order lead, active, trail, and a strobe is only ever high while chip select is high.
- R2: The timing word of zone z sits in `cfg_i[z*26+25 : z*26]`. Its fields, from the top bit down, are: ready-enable, doubling, write lead, write active, write trail, read lead, read active and read trail. Each count field is 4 bits. The zone named in the request selects the word, and the request address is driven on `bus_addr_o` for the whole access.
- R3: A write uses only the write counts and raises `bus_wr_o`. A read uses only the read counts and raises `bus_rd_o`.
- R4: The lead phase lasts LEAD ticks and the trail phase lasts TRAIL ticks. With the doubling flag set, each lasts twice its count.
- R5: The active phase lasts ACTIVE+WS+1 ticks. With the doubling flag set, it lasts 2*ACTIVE+WS+1 ticks.
- R6: When ready-enable is set, `ready_i` is sampled on each tick after the programmed active ticks have passed. Each tick that samples it low adds one wait tick before the final active tick. When ready-enable is clear, `ready_i` has no effect.
- R7: A lead or trail count of zero removes that phase entirely. An active count of zero still gives one active tick.
- R8: For a write, `bus_oe_o` is high and `bus_dout_o` carries the request data for the whole access, lead through trail. For a read, `bus_oe_o` stays low.
- R9: For a read, `bus_din_i` is captured into `rdata_o` on the final active tick and held until the next read captures.
- R10: `done_o` is high for exactly one cycle, in the cycle after the final tick of the access, and the sequencer is then idle.
- R11: Phase counting advances only on clock cycles where `tick_i` is high.
- R12: A request offered while an access is in progress is ignored. A request offered in the cycle where `done_o` is high is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_i | input | NZ*26 | Timing words of all zones |
| req_valid_i | input | 1 | Access request offered |
| req_zone_i | input | ZW | Zone of the request |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| tick_i | input | 1 | Bus timing clock enable |
| ready_i | input | 1 | External ready |
| bus_din_i | input | DW | Data bus input |
| bus_cs_o | output | 1 | Chip select, active high |
| bus_rd_o | output | 1 | Read strobe, active high |
| bus_wr_o | output | 1 | Write strobe, active high |
| bus_addr_o | output | AW | Address bus |
| bus_dout_o | output | DW | Data bus output |
| bus_oe_o | output | 1 | Data bus output enable |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | Access finished, one-cycle pulse |

## Verification
Two events can land in the same cycle. The first pair is a low sample of ready and the tick that would otherwise end the active phase. The second pair is the done pulse and a new request. The bench drives ready from a random stream on zones that honour it and on a zone that ignores it. It chains accesses so that each new request is offered in the very cycle where done is seen. A behavioural tick-counting model decides, every clock, whether the access must wait or move on and whether the chained request must be taken. It compares every bus output against that decision.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    parameter int CNT_W = 4;
    localparam int LEN_W = CNT_W + 1;
    localparam int REM_W = LEN_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] trail;
    } dir_tim_t;

    typedef struct packed {
        logic     rdy_en;
        logic     dbl;
        dir_tim_t wr;
        dir_tim_t rd;
    } zone_cfg_t;

    localparam int CFG_W = $bits(zone_cfg_t);

    typedef struct packed {
        logic [LEN_W-1:0] lead;
        logic [LEN_W-1:0] act;
        logic [LEN_W-1:0] trail;
        logic             rdy_en;
    } acc_len_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_ACT   = 2'd2,
        PH_TRAIL = 2'd3
    } phase_e;

    function automatic logic [LEN_W-1:0] scale_cnt(input logic [CNT_W-1:0] v,
                                                   input logic dbl);
        return dbl ? {v, 1'b0} : {1'b0, v};
    endfunction

endpackage

// File: rtl/ebs_zone_sel.sv
module ebs_zone_sel
    import ebs_pkg::*;
#(
    parameter int NZ = 4,
    parameter int ZW = 2
) (
    input  logic [NZ*CFG_W-1:0] cfg_i,
    input  logic [ZW-1:0]       zone_i,
    input  logic                wr_i,
    output acc_len_t            len_o
);

    zone_cfg_t cfg_arr [NZ];

    for (genvar z = 0; z < NZ; z++) begin : g_unpack
        assign cfg_arr[z] = zone_cfg_t'(cfg_i[z*CFG_W +: CFG_W]);
    end

    zone_cfg_t sel;
    dir_tim_t  tim;

    always_comb begin
        sel          = cfg_arr[zone_i];
        tim          = wr_i ? sel.wr : sel.rd;
        len_o.lead   = scale_cnt(tim.lead, sel.dbl);
        len_o.act    = scale_cnt(tim.act, sel.dbl);
        len_o.trail  = scale_cnt(tim.trail, sel.dbl);
        len_o.rdy_en = sel.rdy_en;
    end

endmodule

// File: rtl/ebs_phase_ctl.sv
module ebs_phase_ctl
    import ebs_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     start_i,
    input  acc_len_t len_i,
    input  logic     tick_i,
    input  logic     ready_i,
    output phase_e   phase_o,
    output logic     capture_o,
    output logic     done_o
);

    localparam logic [REM_W-1:0] ONE = REM_W'(1);

    phase_e           ph_q, ph_d;
    logic [REM_W-1:0] rem_q, rem_d;
    acc_len_t         len_q;
    logic             done_q, done_d;
    logic             cap;
    logic             stall;

    assign stall = len_q.rdy_en && !ready_i;

    always_comb begin
        ph_d   = ph_q;
        rem_d  = rem_q;
        cap    = 1'b0;
        done_d = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (start_i) begin
                    if (len_i.lead != '0) begin
                        ph_d  = PH_LEAD;
                        rem_d = {1'b0, len_i.lead};
                    end else begin
                        ph_d  = PH_ACT;
                        rem_d = {1'b0, len_i.act} + ONE;
                    end
                end
            end
            PH_LEAD: begin
                if (tick_i) begin
                    if (rem_q == ONE) begin
                        ph_d  = PH_ACT;
                        rem_d = {1'b0, len_q.act} + ONE;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
            end
            PH_ACT: begin
                if (tick_i) begin
                    if (rem_q != ONE) begin
                        rem_d = rem_q - ONE;
                    end else if (!stall) begin
                        cap = 1'b1;
                        if (len_q.trail != '0) begin
                            ph_d  = PH_TRAIL;
                            rem_d = {1'b0, len_q.trail};
                        end else begin
                            ph_d   = PH_IDLE;
                            done_d = 1'b1;
                        end
                    end
                end
            end
            PH_TRAIL: begin
                if (tick_i) begin
                    if (rem_q == ONE) begin
                        ph_d   = PH_IDLE;
                        done_d = 1'b1;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q   <= PH_IDLE;
            rem_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            rem_q  <= rem_d;
            done_q <= done_d;
            if (ph_q == PH_IDLE && start_i) begin
                len_q <= len_i;
            end
        end
    end

    assign phase_o   = ph_q;
    assign capture_o = cap;
    assign done_o    = done_q;

    // R11: without a tick nothing in a running access moves
    assert_hold_no_tick_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q != PH_IDLE && !tick_i) |=> ($stable(ph_q) && $stable(rem_q)));

    // R6: a low ready on the closing active tick keeps the active phase
    assert_ready_wait_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q == PH_ACT && rem_q == ONE && tick_i && len_q.rdy_en && !ready_i)
        |=> (ph_q == PH_ACT));

    // R10: done is a single-cycle pulse seen while idle
    assert_done_single_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |=> !done_q);

    assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        done_q |-> (ph_q == PH_IDLE));

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int NZ = 4,
    parameter int AW = 16,
    parameter int DW = 16,
    localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NZ*CFG_W-1:0] cfg_i,
    input  logic                req_valid_i,
    input  logic [ZW-1:0]       req_zone_i,
    input  logic                req_wr_i,
    input  logic [AW-1:0]       req_addr_i,
    input  logic [DW-1:0]       req_wdata_i,
    input  logic                tick_i,
    input  logic                ready_i,
    input  logic [DW-1:0]       bus_din_i,
    output logic                bus_cs_o,
    output logic                bus_rd_o,
    output logic                bus_wr_o,
    output logic [AW-1:0]       bus_addr_o,
    output logic [DW-1:0]       bus_dout_o,
    output logic                bus_oe_o,
    output logic [DW-1:0]       rdata_o,
    output logic                done_o
);

    acc_len_t      req_len;
    phase_e        phase;
    logic          capture;
    logic          start;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    assign start = req_valid_i && (phase == PH_IDLE);

    ebs_zone_sel #(
        .NZ (NZ),
        .ZW (ZW)
    ) u_zone_sel (
        .cfg_i  (cfg_i),
        .zone_i (req_zone_i),
        .wr_i   (req_wr_i),
        .len_o  (req_len)
    );

    ebs_phase_ctl u_phase_ctl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .start_i   (start),
        .len_i     (req_len),
        .tick_i    (tick_i),
        .ready_i   (ready_i),
        .phase_o   (phase),
        .capture_o (capture),
        .done_o    (done_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                wr_q    <= req_wr_i;
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
            end
            if (capture && !wr_q) begin
                rdata_q <= bus_din_i;
            end
        end
    end

    assign bus_cs_o   = (phase != PH_IDLE);
    assign bus_rd_o   = (phase == PH_ACT) && !wr_q;
    assign bus_wr_o   = (phase == PH_ACT) && wr_q;
    assign bus_oe_o   = (phase != PH_IDLE) && wr_q;
    assign bus_addr_o = addr_q;
    assign bus_dout_o = wdata_q;
    assign rdata_o    = rdata_q;

    // R1: strobes only inside chip select, never both
    assert_strobe_in_cs_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_o || bus_wr_o) |-> bus_cs_o);

    assert_one_strobe_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones({bus_rd_o, bus_wr_o}) <= 1);

    // R2 R12: the address holds while an access runs
    assert_addr_hold_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_cs_o |=> $stable(bus_addr_o));

    // R8: the data bus is driven only for writes
    assert_oe_write_only_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_oe_o |-> !bus_rd_o);

    // R9: captured read data changes only on the cycle after an active phase
    assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase != PH_ACT) |=> $stable(rdata_o));

endmodule

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;

    localparam int NZ = 4;
    localparam int CW = 26;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic [NZ*CW-1:0] cfg;
    logic             req_valid;
    logic [1:0]       req_zone;
    logic             req_wr;
    logic [15:0]      req_addr;
    logic [15:0]      req_wdata;
    logic             tick;
    logic             ready;
    logic [15:0]      din;
    logic             bus_cs, bus_rd, bus_wr, bus_oe, done;
    logic [15:0]      bus_addr, bus_dout, rdata;

    ext_bus_seq dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .cfg_i       (cfg),
        .req_valid_i (req_valid),
        .req_zone_i  (req_zone),
        .req_wr_i    (req_wr),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .tick_i      (tick),
        .ready_i     (ready),
        .bus_din_i   (din),
        .bus_cs_o    (bus_cs),
        .bus_rd_o    (bus_rd),
        .bus_wr_o    (bus_wr),
        .bus_addr_o  (bus_addr),
        .bus_dout_o  (bus_dout),
        .bus_oe_o    (bus_oe),
        .rdata_o     (rdata),
        .done_o      (done)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    int lead_c [NZ][2];
    int act_c  [NZ][2];
    int trl_c  [NZ][2];
    bit dbl_c  [NZ];
    bit rdy_c  [NZ];

    int tick_div = 1;
    int tick_cnt = 0;
    bit ready_rand = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == 0);
        ready    <= ready_rand ? ($urandom % 3 != 0) : 1'b1;
        din      <= 16'($urandom);
    end

    // behavioural reference: counts ticks spent in each phase
    int          m_ph = 0, m_el = 0, m_le = 0, m_ae = 0, m_te = 0;
    bit          m_wr = 0, m_rdy = 0, m_done = 0;
    logic [15:0] m_addr = '0, m_wd = '0, m_rd = '0;

    always @(posedge clk) begin
        logic [25:0] w;
        int k;
        m_done = 0;
        if (rst) begin
            m_ph = 0;
            m_rd = '0;
        end else if (m_ph == 0) begin
            if (req_valid) begin
                w      = cfg[int'(req_zone)*CW +: CW];
                k      = w[24] ? 2 : 1;
                m_rdy  = w[25];
                m_wr   = req_wr;
                m_addr = req_addr;
                m_wd   = req_wdata;
                if (req_wr) begin
                    m_le = k * int'(w[23:20]);
                    m_ae = k * int'(w[19:16]);
                    m_te = k * int'(w[15:12]);
                end else begin
                    m_le = k * int'(w[11:8]);
                    m_ae = k * int'(w[7:4]);
                    m_te = k * int'(w[3:0]);
                end
                m_el = 0;
                m_ph = (m_le > 0) ? 1 : 2;
            end
        end else if (tick) begin
            case (m_ph)
                1: begin
                    m_el++;
                    if (m_el >= m_le) begin
                        m_ph = 2;
                        m_el = 0;
                    end
                end
                2: begin
                    if (m_el < m_ae) begin
                        m_el++;
                    end else if (!(m_rdy && !ready)) begin
                        if (!m_wr) m_rd = din;
                        m_el = 0;
                        if (m_te > 0) m_ph = 3;
                        else begin
                            m_ph = 0;
                            m_done = 1;
                        end
                    end
                end
                default: begin
                    m_el++;
                    if (m_el >= m_te) begin
                        m_ph = 0;
                        m_done = 1;
                    end
                end
            endcase
        end
    end

    always @(negedge clk) begin
        cycles++;
        chk("R1 R11 chip select", bus_cs, m_ph != 0);
        chk("R5 R6 read strobe", bus_rd, (m_ph == 2) && !m_wr);
        chk("R3 write strobe", bus_wr, (m_ph == 2) && m_wr);
        chk("R8 output enable", bus_oe, (m_ph != 0) && m_wr);
        if (m_ph != 0) chk("R2 R12 address", bus_addr, m_addr);
        if (m_ph != 0 && m_wr) chk("R8 write data", bus_dout, m_wd);
        chk("R10 done pulse", done, m_done);
        chk("R9 read data", rdata, m_rd);
        if (cycles >= 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic int exp_ticks(int z, int wr);
        int k;
        k = dbl_c[z] ? 2 : 1;
        return k * lead_c[z][wr] + k * act_c[z][wr] + 1 + k * trl_c[z][wr];
    endfunction

    task automatic offer(int z, bit wr, logic [15:0] a, logic [15:0] d);
        req_valid = 1'b1;
        req_zone  = 2'(z);
        req_wr    = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // offers an access at the current negedge, waits for done; counts chip-select cycles
    task automatic access(int z, bit wr, logic [15:0] a, logic [15:0] d, bit chk_len,
                          string tag);
        int n = 0;
        int guard = 0;
        offer(z, wr, a, d);
        while (!done && guard < 2000) begin
            if (bus_cs) n++;
            guard++;
            if (!done) @(negedge clk);
        end
        if (chk_len) chk(tag, n, exp_ticks(z, wr));
    endtask

    task automatic set_zone(int z, bit re, bit db, int wl, int wa, int wt,
                            int rl, int ra, int rt);
        rdy_c[z] = re; dbl_c[z] = db;
        lead_c[z][1] = wl; act_c[z][1] = wa; trl_c[z][1] = wt;
        lead_c[z][0] = rl; act_c[z][0] = ra; trl_c[z][0] = rt;
        cfg[z*CW +: CW] = {re, db, 4'(wl), 4'(wa), 4'(wt), 4'(rl), 4'(ra), 4'(rt)};
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_zone = '0; req_wr = 1'b0;
        req_addr = '0; req_wdata = '0;
        cfg = '0;
        set_zone(0, 0, 0, 2, 3, 1, 1, 2, 2);
        set_zone(1, 1, 0, 0, 0, 0, 0, 1, 0);
        set_zone(2, 0, 1, 3, 2, 1, 2, 5, 3);
        set_zone(3, 1, 1, 1, 15, 15, 15, 0, 1);
        repeat (4) @(negedge clk);
        chk("R10 reset done low", done, 0);
        chk("R1 reset chip select low", bus_cs, 0);
        rst = 1'b0;
        @(negedge clk);

        // full-rate ticks, ready high: durations from the count formulas
        for (int z = 0; z < NZ; z++) begin
            access(z, 1'b1, 16'h1000 + 16'(z), 16'hA500 + 16'(z), 1'b1, "R4 R5 R7 write length");
            access(z, 1'b0, 16'h2000 + 16'(z), 16'h0, 1'b1, "R3 R4 R5 R7 read length");
        end

        // random ready: zone 0 ignores it, exact length still holds
        ready_rand = 1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            access(0, i[0], 16'h3000 + 16'(i), 16'h5A00 + 16'(i), 1'b1, "R6 ready ignored length");
        end
        for (int i = 0; i < 12; i++) begin
            access(1 + 2 * (i % 2), i[1], 16'h4000 + 16'(i), 16'hC300 + 16'(i), 1'b0, "R6");
        end

        // slow ticks with random ready
        tick_div = 3;
        for (int i = 0; i < 8; i++) begin
            access(i % NZ, i[0], 16'h5000 + 16'(i), 16'h3C00 + 16'(i), 1'b0, "R11");
        end

        // R12: a second offer in mid-access is dropped
        ready_rand = 0;
        tick_div = 1;
        @(negedge clk);
        offer(2, 1'b0, 16'h6001, 16'h0);
        repeat (3) @(negedge clk);
        chk("R12 busy offer address before", bus_addr, 16'h6001);
        offer(0, 1'b1, 16'h7777, 16'hFFFF);
        chk("R12 busy offer ignored", bus_addr, 16'h6001);
        chk("R12 busy offer no drive", bus_oe, 0);
        while (!done) @(negedge clk);

        // R12: offer in the done cycle is taken at once
        offer(3, 1'b1, 16'h8001, 16'h1234);
        chk("R12 taken in done cycle", bus_cs, 1);
        chk("R12 taken address", bus_addr, 16'h8001);
        repeat (5) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule